// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core, together with the shadow copies that each processor mode keeps of part of that set. A 5-bit mode code selects a bank through a sparse map. When the core requests a new mode, the block saves the banked registers of the old bank and loads those of the new one, all in a single clock edge. The fast-interrupt bank shadows registers 8 to 14. Every other bank shadows only registers 13 and 14. Mode codes that have no bank of their own fall into a dummy bank that holds nothing.

The execution pipeline reads two registers and writes one through ports addressed by register number. Each privileged bank also has one saved-status word, which is read and written through a port addressed by mode code. A debug port reaches any register as any mode sees it: it uses the live copy when the requested mode shares the current bank, and the saved copy otherwise. The block also drives a privilege signal for the bus, taken from the current mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode output is 19 (supervisor), the privilege output is high, and every register and every saved-status word reads 0.
- R2: Both read ports return the live register at their address without delay. A write with wr_en_i set updates the addressed register at the next clock edge. All 16 addresses can be written.
- R3: When mode_chg_i is high, mode_o takes mode_new_i at the next edge and otherwise holds its value. priv_o is high exactly when bits [1:0] of mode_o are not both 0.
- R4: Bank map by mode code: 0 and 16 select user, 1 and 17 fast-interrupt, 2 and 18 interrupt, 3 and 19 supervisor, 23 abort, 27 undefined and 31 system. Every other code selects the dummy bank.
- R5: A change between two banks, neither of which is fast-interrupt or dummy, saves r13 and r14 into the old bank and loads them from the new bank. r0 to r12 and r15 are left unchanged.
- R6: Entering fast-interrupt saves r8 to r14 (r8 to r12 go to the user copy) and loads r8 to r14 from the fast-interrupt bank. Leaving it saves r8 to r14 into that bank and restores r8 to r12 from the user copy.
- R7: The system bank uses the user bank's r13 and r14. A mode change between two codes that select the same storage (user and system, or 3 and 19) leaves all registers untouched.
- R8: Entering the dummy bank clears r8 to r14. Leaving it saves nothing, loads only the new bank's r13 and r14, and leaves r8 to r12 at the values they held in the dummy bank.
- R9: A register write in the same cycle as a mode change lands in the new mode's register set and takes priority over the value loaded by the swap.
- R10: Fast-interrupt, interrupt, supervisor, abort and undefined each hold one saved-status word, addressed by spsr_mode_i. For user, system and dummy codes the read returns 0 and a write has no effect.
- R11: The debug port uses the live register when dbg_mode_i selects the current storage bank, or when the address is outside r8 to r14. Otherwise it uses that bank's saved copy, and the dummy bank reads as 0.
- R12: A debug write is dropped in a cycle with mode_chg_i high. When it targets the same live register as a pipeline write in the same cycle, the pipeline write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Register write number |
| wr_data_i | input | 32 | Register write data |
| mode_chg_i | input | 1 | Mode change request |
| mode_new_i | input | 5 | Requested mode code |
| mode_o | output | 5 | Current mode code |
| priv_o | output | 1 | Privileged access indication |
| spsr_mode_i | input | 5 | Mode code selecting the saved-status word |
| spsr_rdata_o | output | 32 | Saved-status read data |
| spsr_we_i | input | 1 | Saved-status write enable |
| spsr_wdata_i | input | 32 | Saved-status write data |
| dbg_mode_i | input | 5 | Debug view mode code |
| dbg_addr_i | input | 4 | Debug register number |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_rdata_o | output | 32 | Debug read data |

## Verification
The bench goes after the asymmetric fast-interrupt path. A swap that ignores the user copy on exit would leave the fast-interrupt values in r8 to r12 after returning to user mode. It passes through the dummy bank twice: the second visit must read 0 in r13, and the return must leave r8 cleared, so a design that saved on leaving the dummy bank or restored r8 to r12 there would be exposed. It issues a register write in the same cycle as a mode change, where writing before the swap would let the loaded value overwrite the new data. It also checks the same-bank code pairs and the user/system sharing, which catch a design that compares mode codes instead of banks and swaps when it should not.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned NUM_BANKS = 8;
  localparam int unsigned FIQ_LO    = 8;   // first register shadowed by the fast-interrupt bank
  localparam int unsigned SHR_LO    = 13;  // first register shadowed by every bank
  localparam int unsigned BANK_HI   = 14;  // last shadowed register
  localparam int unsigned SLOT_N    = BANK_HI - FIQ_LO + 1;
  localparam int unsigned LO_N      = SHR_LO - FIQ_LO;
  localparam logic [MODE_W-1:0] RESET_MODE = 5'd19;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2, BK_SVC = 3'd3,
    BK_ABT = 3'd4, BK_UND = 3'd5, BK_SYS = 3'd6, BK_NUL = 3'd7
  } bank_e;

  typedef enum logic [1:0] {TGT_LIVE, TGT_SHD, TGT_NONE} tgt_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      5'd0,  5'd16: return BK_USR;
      5'd1,  5'd17: return BK_FIQ;
      5'd2,  5'd18: return BK_IRQ;
      5'd3,  5'd19: return BK_SVC;
      5'd23:        return BK_ABT;
      5'd27:        return BK_UND;
      5'd31:        return BK_SYS;
      default:      return BK_NUL;
    endcase
  endfunction

  // system mode keeps its r13/r14 in the user row
  function automatic bank_e store_of(input bank_e b);
    return (b == BK_SYS) ? BK_USR : b;
  endfunction

  function automatic logic has_spsr(input bank_e b);
    return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
           (b == BK_ABT) || (b == BK_UND);
  endfunction
endpackage

// File: rtl/mrf_mode_ctrl.sv
module mrf_mode_ctrl
  import mrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chg_i,
  input  logic [MODE_W-1:0] new_mode_i,
  output logic [MODE_W-1:0] mode_o,
  output bank_e             cur_bank_o,
  output bank_e             nxt_bank_o,
  output logic              swap_o,
  output logic              priv_o
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= RESET_MODE;
    else if (chg_i) mode_q <= new_mode_i;
  end

  assign cur_bank_o = store_of(bank_of(mode_q));
  assign nxt_bank_o = store_of(bank_of(new_mode_i));
  assign swap_o     = chg_i && (cur_bank_o != nxt_bank_o);
  assign priv_o     = |mode_q[1:0];
  assign mode_o     = mode_q;
endmodule

// File: rtl/mrf_reg_core.sv
module mrf_reg_core
  import mrf_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned SW      = $clog2(SLOT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_e             cur_bank_i,
  input  bank_e             nxt_bank_i,
  input  logic              swap_i,
  input  logic [AW-1:0]     rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [AW-1:0]     rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  bank_e             dbg_bank_i,
  input  logic [AW-1:0]     dbg_addr_i,
  input  logic              dbg_we_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_rdata_o
);
  logic [DATA_W-1:0] live_q [NUM_REGS];
  logic [DATA_W-1:0] live_d [NUM_REGS];
  logic [DATA_W-1:0] shd_q  [NUM_BANKS][SLOT_N];
  logic [DATA_W-1:0] shd_d  [NUM_BANKS][SLOT_N];

  tgt_e          dbg_tgt;
  bank_e         dbg_sb;
  logic [SW-1:0] dbg_slot;
  logic          dbg_in_bank;

  // where a debug access lands
  always_comb begin
    dbg_tgt     = TGT_LIVE;
    dbg_sb      = BK_USR;
    dbg_slot    = SW'(dbg_addr_i - AW'(FIQ_LO));
    dbg_in_bank = (dbg_addr_i >= AW'(FIQ_LO)) && (dbg_addr_i <= AW'(BANK_HI));
    if (dbg_in_bank && (dbg_bank_i != cur_bank_i)) begin
      if (dbg_bank_i == BK_NUL) begin
        dbg_tgt = TGT_NONE;
      end else if ((dbg_addr_i >= AW'(SHR_LO)) || (dbg_bank_i == BK_FIQ)) begin
        dbg_tgt = TGT_SHD;
        dbg_sb  = dbg_bank_i;
      end else if (cur_bank_i == BK_FIQ) begin
        dbg_tgt = TGT_SHD;  // user view of r8-r12 while fast-interrupt is live
        dbg_sb  = BK_USR;
      end
    end
  end

  always_comb begin
    live_d = live_q;
    shd_d  = shd_q;
    if (swap_i) begin
      // save from the old bank
      if (cur_bank_i == BK_FIQ) begin
        for (int k = 0; k < SLOT_N; k++) shd_d[BK_FIQ][k] = live_q[FIQ_LO+k];
      end else if (cur_bank_i != BK_NUL) begin
        if (nxt_bank_i == BK_FIQ)
          for (int k = 0; k < LO_N; k++) shd_d[BK_USR][k] = live_q[FIQ_LO+k];
        for (int k = LO_N; k < SLOT_N; k++) shd_d[cur_bank_i][k] = live_q[FIQ_LO+k];
      end
      // load for the new bank
      if (nxt_bank_i == BK_NUL) begin
        for (int k = 0; k < SLOT_N; k++) live_d[FIQ_LO+k] = '0;
      end else if (nxt_bank_i == BK_FIQ) begin
        for (int k = 0; k < SLOT_N; k++) live_d[FIQ_LO+k] = shd_q[BK_FIQ][k];
      end else begin
        if (cur_bank_i == BK_FIQ)
          for (int k = 0; k < LO_N; k++) live_d[FIQ_LO+k] = shd_q[BK_USR][k];
        for (int k = LO_N; k < SLOT_N; k++) live_d[FIQ_LO+k] = shd_q[nxt_bank_i][k];
      end
    end else if (dbg_we_i && (dbg_tgt == TGT_SHD)) begin
      shd_d[dbg_sb][dbg_slot] = dbg_wdata_i;
    end
    if (dbg_we_i && (dbg_tgt == TGT_LIVE)) live_d[dbg_addr_i] = dbg_wdata_i;
    if (wr_en_i) live_d[wr_addr_i] = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) live_q[r] <= '0;
      for (int b = 0; b < NUM_BANKS; b++)
        for (int k = 0; k < SLOT_N; k++) shd_q[b][k] <= '0;
    end else begin
      live_q <= live_d;
      shd_q  <= shd_d;
    end
  end

  assign rd_a_data_o = live_q[rd_a_addr_i];
  assign rd_b_data_o = live_q[rd_b_addr_i];

  always_comb begin
    case (dbg_tgt)
      TGT_LIVE: dbg_rdata_o = live_q[dbg_addr_i];
      TGT_SHD:  dbg_rdata_o = shd_q[dbg_sb][dbg_slot];
      default:  dbg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mrf_spsr_file.sv
module mrf_spsr_file
  import mrf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_e             sel_bank_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_BANKS-1:0][DATA_W-1:0] spsr_vec;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    if (has_spsr(bank_e'(g))) begin : g_keep
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                        word_q <= '0;
        else if (we_i && (sel_bank_i == bank_e'(g)))        word_q <= wdata_i;
      end
      assign spsr_vec[g] = word_q;
    end else begin : g_none
      assign spsr_vec[g] = '0;
    end
  end

  assign rdata_o = spsr_vec[sel_bank_i];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import mrf_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [AW-1:0]     rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mode_chg_i,
  input  logic [MODE_W-1:0] mode_new_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              priv_o,
  input  logic [MODE_W-1:0] spsr_mode_i,
  output logic [DATA_W-1:0] spsr_rdata_o,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  input  logic [MODE_W-1:0] dbg_mode_i,
  input  logic [AW-1:0]     dbg_addr_i,
  input  logic              dbg_we_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_rdata_o
);
  bank_e cur_bank, nxt_bank, dbg_bank, spsr_bank;
  logic  swap;
  logic  dbg_we_ok;

  assign dbg_bank  = store_of(bank_of(dbg_mode_i));
  assign spsr_bank = bank_of(spsr_mode_i);
  assign dbg_we_ok = dbg_we_i && !mode_chg_i;

  mrf_mode_ctrl u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chg_i      (mode_chg_i),
    .new_mode_i (mode_new_i),
    .mode_o     (mode_o),
    .cur_bank_o (cur_bank),
    .nxt_bank_o (nxt_bank),
    .swap_o     (swap),
    .priv_o     (priv_o)
  );

  mrf_reg_core #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_bank_i  (cur_bank),
    .nxt_bank_i  (nxt_bank),
    .swap_i      (swap),
    .rd_a_addr_i (rd_a_addr_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_addr_i (rd_b_addr_i),
    .rd_b_data_o (rd_b_data_o),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .dbg_bank_i  (dbg_bank),
    .dbg_addr_i  (dbg_addr_i),
    .dbg_we_i    (dbg_we_ok),
    .dbg_wdata_i (dbg_wdata_i),
    .dbg_rdata_o (dbg_rdata_o)
  );

  mrf_spsr_file #(.DATA_W(DATA_W)) u_spsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_bank_i (spsr_bank),
    .we_i       (spsr_we_i),
    .wdata_i    (spsr_wdata_i),
    .rdata_o    (spsr_rdata_o)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import mrf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        rd_a_addr_i,
  input logic [31:0]       rd_a_data_o,
  input logic              wr_en_i,
  input logic              mode_chg_i,
  input logic [MODE_W-1:0] mode_new_i,
  input logic [MODE_W-1:0] mode_o,
  input logic              priv_o,
  input logic [MODE_W-1:0] spsr_mode_i,
  input logic [31:0]       spsr_rdata_o,
  input logic              dbg_we_i
);
  a_r3_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> (mode_o == $past(mode_new_i)));

  a_r3_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_chg_i |=> $stable(mode_o));

  a_r3_priv_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 5'd16) || (mode_o == 5'd0) || (mode_o == 5'd20)) |-> !priv_o);

  a_r3_priv_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 5'd17) || (mode_o == 5'd19) || (mode_o == 5'd31)) |-> priv_o);

  a_r10_spsr_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_spsr(bank_of(spsr_mode_i)) |-> (spsr_rdata_o == '0));

  a_r8_null_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_chg_i && !wr_en_i && (bank_of(mode_new_i) == BK_NUL) &&
     (bank_of(mode_o) != BK_NUL))
    |=> ((rd_a_addr_i < 4'd8) || (rd_a_addr_i == 4'd15) || (rd_a_data_o == '0)));

  a_r2_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_chg_i && !wr_en_i && !dbg_we_i)
    |=> (!$stable(rd_a_addr_i) || $stable(rd_a_data_o)));
endmodule

bind banked_regfile banked_regfile_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_a_addr_i  (rd_a_addr_i),
  .rd_a_data_o  (rd_a_data_o),
  .wr_en_i      (wr_en_i),
  .mode_chg_i   (mode_chg_i),
  .mode_new_i   (mode_new_i),
  .mode_o       (mode_o),
  .priv_o       (priv_o),
  .spsr_mode_i  (spsr_mode_i),
  .spsr_rdata_o (spsr_rdata_o),
  .dbg_we_i     (dbg_we_i)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0, dbg_addr = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, spsr_rdata, spsr_wdata = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic        wr_en = 1'b0, mode_chg = 1'b0, spsr_we = 1'b0, dbg_we = 1'b0, priv;
  logic [4:0]  mode_new = '0, mode, spsr_mode = '0, dbg_mode = '0;
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  banked_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_addr_i(rd_a_addr), .rd_a_data_o(rd_a_data),
    .rd_b_addr_i(rd_b_addr), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .mode_chg_i(mode_chg), .mode_new_i(mode_new), .mode_o(mode), .priv_o(priv),
    .spsr_mode_i(spsr_mode), .spsr_rdata_o(spsr_rdata),
    .spsr_we_i(spsr_we), .spsr_wdata_i(spsr_wdata),
    .dbg_mode_i(dbg_mode), .dbg_addr_i(dbg_addr), .dbg_we_i(dbg_we),
    .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chmode(input logic [4:0] m);
    mode_chg = 1'b1; mode_new = m;
    step();
    mode_chg = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    rd_a_addr = a; rd_b_addr = a;
    #1;
    check(req, rd_a_data, exp);
    check(req, rd_b_data, exp);
  endtask

  task automatic dbg_rd(input string req, input logic [4:0] m, input logic [3:0] a,
                        input logic [31:0] exp);
    dbg_mode = m; dbg_addr = a;
    #1;
    check(req, dbg_rdata, exp);
  endtask

  task automatic t_reset();
    check("R1 mode", 32'(mode), 32'd19);
    check("R1 priv", 32'(priv), 32'd1);
    for (int r = 0; r < 16; r++) rd("R1 reg", 4'(r), '0);
    spsr_mode = 5'd19; #1;
    check("R1 spsr", spsr_rdata, '0);
  endtask

  task automatic t_basic();
    for (int r = 0; r < 16; r++) wr(4'(r), 32'h100 + 32'(r));
    for (int r = 0; r < 16; r++) rd("R2 readback", 4'(r), 32'h100 + 32'(r));
  endtask

  task automatic t_irq_swap();
    chmode(5'd18);
    rd("R5 irq r13 empty", 4'd13, '0);
    rd("R5 irq r14 empty", 4'd14, '0);
    rd("R5 r8 kept", 4'd8, 32'h108);
    rd("R5 r0 kept", 4'd0, 32'h100);
    rd("R5 r15 kept", 4'd15, 32'h10F);
    wr(4'd13, 32'hAAAA0013);
    wr(4'd14, 32'hAAAA0014);
    chmode(5'd19);
    rd("R5 svc r13 back", 4'd13, 32'h10D);
    rd("R5 svc r14 back", 4'd14, 32'h10E);
    chmode(5'd18);
    rd("R5 irq r13 back", 4'd13, 32'hAAAA0013);
  endtask

  task automatic t_fiq();
    chmode(5'd19);
    chmode(5'd17);
    for (int r = 8; r < 15; r++) rd("R6 fiq load", 4'(r), '0);
    for (int r = 8; r < 15; r++) wr(4'(r), 32'hF0 + 32'(r));
    chmode(5'd16);
    for (int r = 8; r < 13; r++) rd("R6 user copy restored", 4'(r), 32'h100 + 32'(r));
    rd("R6 user r13", 4'd13, '0);
    chmode(5'd17);
    for (int r = 8; r < 15; r++) rd("R6 fiq kept", 4'(r), 32'hF0 + 32'(r));
  endtask

  task automatic t_sys();
    chmode(5'd16);
    wr(4'd13, 32'h5513);
    chmode(5'd31);
    rd("R7 sys shares r13", 4'd13, 32'h5513);
    rd("R7 no swap r8", 4'd8, 32'h108);
    wr(4'd14, 32'h5514);
    chmode(5'd0);
    rd("R7 same bank r14", 4'd14, 32'h5514);
    chmode(5'd19);
    rd("R7 svc r13", 4'd13, 32'h10D);
    chmode(5'd16);
    rd("R7 user r13", 4'd13, 32'h5513);
    rd("R7 user r14", 4'd14, 32'h5514);
  endtask

  task automatic t_dummy();
    wr(4'd8, 32'h77);
    chmode(5'd4);
    for (int r = 8; r < 15; r++) rd("R8 dummy clear", 4'(r), '0);
    rd("R8 r0 kept", 4'd0, 32'h100);
    wr(4'd13, 32'h99);
    chmode(5'd16);
    rd("R8 user r13 loaded", 4'd13, 32'h5513);
    rd("R8 r8 stays clear", 4'd8, '0);
    chmode(5'd4);
    rd("R8 dummy not saved", 4'd13, '0);
    chmode(5'd16);
    rd("R8 user r13 again", 4'd13, 32'h5513);
  endtask

  task automatic t_concurrent();
    mode_chg = 1'b1; mode_new = 5'd18;
    wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'hC0DE;
    step();
    mode_chg = 1'b0; wr_en = 1'b0;
    rd("R9 write in new set", 4'd13, 32'hC0DE);
    chmode(5'd16);
    rd("R9 user untouched", 4'd13, 32'h5513);
    chmode(5'd18);
    rd("R9 irq saved", 4'd13, 32'hC0DE);
  endtask

  task automatic t_map();
    chmode(5'd19);
    wr(4'd13, 32'h5A13);
    chmode(5'd3);
    rd("R4 code 3 is svc", 4'd13, 32'h5A13);
    chmode(5'd23);
    rd("R4 abt empty", 4'd13, '0);
    wr(4'd13, 32'hAB);
    chmode(5'd27);
    rd("R4 und empty", 4'd13, '0);
    wr(4'd13, 32'h0D);
    chmode(5'd23);
    rd("R4 abt kept", 4'd13, 32'hAB);
    chmode(5'd27);
    rd("R4 und kept", 4'd13, 32'h0D);
    chmode(5'd24);
    rd("R4 code 24 dummy", 4'd13, '0);
    chmode(5'd19);
    rd("R4 svc kept", 4'd13, 32'h5A13);
  endtask

  task automatic t_spsr();
    logic [4:0] wm [8] = '{5'd17, 5'd18, 5'd19, 5'd23, 5'd27, 5'd16, 5'd31, 5'd4};
    for (int i = 0; i < 8; i++) begin
      spsr_mode = wm[i]; spsr_we = 1'b1; spsr_wdata = 32'h5000 + 32'(wm[i]);
      step();
    end
    spsr_we = 1'b0;
    for (int i = 0; i < 5; i++) begin
      spsr_mode = wm[i]; #1;
      check("R10 spsr kept", spsr_rdata, 32'h5000 + 32'(wm[i]));
    end
    for (int i = 5; i < 8; i++) begin
      spsr_mode = wm[i]; #1;
      check("R10 spsr none", spsr_rdata, '0);
    end
    spsr_mode = 5'd1; #1;
    check("R10 code 1 shares fiq", spsr_rdata, 32'h5011);
    spsr_mode = 5'd0; #1;
    check("R10 code 0 none", spsr_rdata, '0);
  endtask

  task automatic t_debug();
    chmode(5'd19);
    wr(4'd13, 32'h5D13);
    chmode(5'd18);
    wr(4'd13, 32'h1D13);
    dbg_rd("R11 saved svc r13", 5'd19, 4'd13, 32'h5D13);
    dbg_rd("R11 live irq r13", 5'd18, 4'd13, 32'h1D13);
    dbg_rd("R11 code 2 live", 5'd2, 4'd13, 32'h1D13);
    dbg_rd("R11 saved fiq r8", 5'd17, 4'd8, 32'hF8);
    dbg_rd("R11 dummy zero", 5'd4, 4'd13, '0);
    dbg_rd("R11 unbanked r0", 5'd17, 4'd0, 32'h100);
    dbg_mode = 5'd19; dbg_addr = 4'd13; dbg_we = 1'b1; dbg_wdata = 32'h5EEE;
    step();
    dbg_we = 1'b0;
    rd("R11 live untouched", 4'd13, 32'h1D13);
    // debug write alongside a mode change is dropped
    dbg_mode = 5'd19; dbg_addr = 4'd14; dbg_we = 1'b1; dbg_wdata = 32'hDEAD;
    chmode(5'd19);
    dbg_we = 1'b0;
    rd("R11 saved write landed", 4'd13, 32'h5EEE);
    rd("R12 dropped write", 4'd14, 32'h10E);
    dbg_mode = 5'd19; dbg_addr = 4'd5; dbg_we = 1'b1; dbg_wdata = 32'h2222;
    wr(4'd5, 32'h1111);
    dbg_we = 1'b0;
    rd("R12 pipeline wins", 4'd5, 32'h1111);
    dbg_mode = 5'd31; dbg_addr = 4'd6; dbg_we = 1'b1; dbg_wdata = 32'h6666;
    step();
    dbg_we = 1'b0;
    rd("R11 unbanked write live", 4'd6, 32'h6666);
  endtask

  task automatic t_priv();
    logic [4:0] pm [11] = '{5'd16, 5'd0, 5'd4, 5'd20, 5'd17, 5'd18, 5'd19,
                            5'd31, 5'd23, 5'd27, 5'd1};
    for (int i = 0; i < 11; i++) begin
      chmode(pm[i]);
      check("R3 mode", 32'(mode), 32'(pm[i]));
      check("R3 priv", 32'(priv), 32'(|pm[i][1:0]));
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog got=%h exp=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_irq_swap();
    t_fiq();
    t_sys();
    t_dummy();
    t_concurrent();
    t_map();
    t_spsr();
    t_debug();
    t_priv();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule